// File: doc/BRIEF.md
# Delayed Register Write Queue

This block holds register-file updates that have been scheduled but may only land a fixed number of instruction cycles later. Load-delay slots on early pipelined processors work this way. A producer hands in one update at a time: a flat destination register number, a 64-bit value, a delay, a width (32 or 64 bits) and, optionally, the position of a single bit to set or clear. Each held update counts down once per `tick`, which the core pulses once for every issued instruction. When the count runs out, the update leaves through a write lane of the register file.

The queue is a ring of `SLOTS` entries. New updates are allocated in rotation, and slots are freed strictly oldest-first. An update with a short delay that sits behind one with a long delay is still written on time. Its slot, however, stays occupied until every older entry has been written. A legacy "fill" request forces a delay of two and a full 64-bit write. The flat register number is split into a bank flag and a local index: numbers 38 to 69 address the floating-point bank as index 0 to 31, and every other number addresses the general bank unchanged.

The schedule interface is valid/ready. `sch_ready` is high while the slot at the insert position is free, and it is computed from the current state only: a slot freed by a tick in the same cycle is not offered until the next cycle. A schedule presented while `sch_ready` is low is not stored. It is reported on `ovf_err`. The write lanes have no back-pressure. The register file must accept every lane write in the cycle it is presented, applying `dest = (dest & ~mask) | (data & mask)`. `inval` synchronously discards all held work.

Top module: `delayed_write_queue`

## Requirements
- R1: After reset, all `wr_en` bits, `ovf_err` and `ptr_err` are 0, and `sch_ready` is 1.
- R2: An update accepted with delay N is written on the (N+1)-th tick edge after the acceptance edge. `wr_en` for its lane is high for exactly the one cycle after that tick edge, and no lane is ever enabled without a tick on the previous edge.
- R3: A tick sampled on the same edge that accepts an update does not count toward that update's delay.
- R4: A full write with `sch_wide`=1 drives an all-ones mask and the stored value. With `sch_wide`=0 it drives mask `0x0000_0000_FFFF_FFFF` and the stored value ANDed with that mask.
- R5: With `sch_bit_en`=1, the mask has only bit `sch_bit` set, limited to the low 32 bits when `sch_wide`=0 (so bit 32 or above gives an empty mask). Data equals the mask if the stored value is nonzero and 0 otherwise.
- R6: `sch_ready` is 0 exactly when all `SLOTS` entries are held. A schedule with `sch_valid`=1 and `sch_ready`=0 is not stored, and `ovf_err` is 1 in the following cycle.
- R7: Slots are freed oldest-first. A written entry keeps its slot until every older entry has also been written, so `sch_ready` stays 0 until the oldest entry retires.
- R8: With `sch_fill`=1, the delay is 2 and the write is full 64-bit, whatever `sch_delay`, `sch_wide` or `sch_bit_en` hold. Register numbers 38 to 69 give `wr_fpr`=1 and `wr_idx` = number minus 38; all other numbers give `wr_fpr`=0 and `wr_idx` = number. The same mapping applies to every update.
- R9: `ptr_err` is 1 in the cycle after a tick that finds the insert and remove positions different while the occupancy count is 0. It stays 0 in all normal operation.
- R10: `inval` discards every held update. No lane is written afterwards for those updates, no schedule is accepted in the `inval` cycle, and `ovf_err` is not raised in that cycle.
- R11: Slot allocation starts at lane 0 after reset or `inval` and advances by one per accepted update, wrapping after `SLOTS-1`. Each update is written on the lane numbered by its slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inval | input | 1 | Synchronous discard of all held updates |
| sch_valid | input | 1 | Schedule request valid |
| sch_ready | output | 1 | Insert slot free; request is accepted when both valid and ready are high |
| sch_fill | input | 1 | Legacy fill: delay 2, full 64-bit write |
| sch_reg | input | 7 | Flat destination register number |
| sch_data | input | 64 | Value to write (or bit set/clear selector) |
| sch_delay | input | DLY_W (4) | Delay in ticks |
| sch_wide | input | 1 | 1 = 64-bit destination, 0 = 32-bit |
| sch_bit_en | input | 1 | Update a single bit only |
| sch_bit | input | 6 | Bit position for a single-bit update |
| tick | input | 1 | One pulse per issued instruction |
| wr_en | output | SLOTS | Per-lane write enable |
| wr_fpr | output | SLOTS | Per-lane bank flag (1 = floating-point bank) |
| wr_idx | output | SLOTS*7 | Per-lane register index within the bank |
| wr_data | output | SLOTS*64 | Per-lane write data |
| wr_mask | output | SLOTS*64 | Per-lane bit mask |
| ovf_err | output | 1 | Schedule rejected in the previous cycle |
| ptr_err | output | 1 | Pointer/occupancy mismatch seen on the previous tick |

## Verification
Every result of this block is registered once. A lane write, an `ovf_err` pulse and a `ptr_err` pulse all appear in the cycle after the clock edge that sampled their cause. A lane write's cause is the tick edge on which the countdown, loaded with delay+1 on the acceptance edge, reaches zero. `sch_ready` is a function of the current state and is valid throughout a cycle. The bench drives inputs on the falling edge. It advances its own model of ordered pending updates once per cycle at that moment. It compares every output on the next falling edge, which is after the rising edge that makes the result visible and before the following one.

// File: rtl/dwq_pkg.sv
package dwq_pkg;
  localparam int DATA_W       = 64;
  localparam int NARROW_W     = 32;
  localparam int REG_W        = 7;
  localparam int BIT_W        = 6;
  localparam int BANK_BASE    = 38;
  localparam int BANK_SIZE    = 32;
  localparam int LEGACY_DELAY = 2;

  typedef struct packed {
    logic [REG_W-1:0]  dst;
    logic [DATA_W-1:0] val;
    logic              wide;
    logic              bit_en;
    logic [BIT_W-1:0]  bitn;
  } wr_ent_t;
endpackage

// File: rtl/dwq_bank_map.sv
module dwq_bank_map
  import dwq_pkg::*;
(
  input  logic [REG_W-1:0] flat_i,
  output logic             fpr_o,
  output logic [REG_W-1:0] idx_o
);
  localparam logic [REG_W-1:0] LO = REG_W'(BANK_BASE);
  localparam logic [REG_W-1:0] HI = REG_W'(BANK_BASE + BANK_SIZE);

  always_comb begin
    fpr_o = (flat_i >= LO) && (flat_i < HI);
    idx_o = fpr_o ? (flat_i - LO) : flat_i;
  end
endmodule

// File: rtl/dwq_slot.sv
module dwq_slot
  import dwq_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             load_i,
  input  wr_ent_t          ent_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic             tick_i,
  input  logic             release_i,
  output logic             live_o,
  output logic             done_o,
  output logic             expire_o,
  output wr_ent_t          ent_o
);
  localparam int CW = DLY_W + 1;

  logic [CW-1:0] cnt_q;

  assign expire_o = tick_i && live_o && !done_o && (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_o <= 1'b0;
      done_o <= 1'b0;
      cnt_q  <= '0;
      ent_o  <= '0;
    end else if (clr_i) begin
      live_o <= 1'b0;
      done_o <= 1'b0;
      cnt_q  <= '0;
    end else if (release_i) begin
      live_o <= 1'b0;
      done_o <= 1'b0;
    end else if (load_i) begin
      live_o <= 1'b1;
      done_o <= 1'b0;
      cnt_q  <= CW'(delay_i) + CW'(1);
      ent_o  <= ent_i;
    end else if (tick_i && live_o && !done_o) begin
      cnt_q <= cnt_q - CW'(1);
      if (expire_o) done_o <= 1'b1;
    end
  end

  AST_SLOT_LOAD_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !live_o); // R6
  AST_SLOT_RELEASE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    release_i |-> (live_o && (done_o || expire_o))); // R7
  AST_SLOT_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (live_o && !done_o) |-> (cnt_q != '0)); // R2
  AST_SLOT_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !release_i && !clr_i) |=> done_o); // R7
endmodule

// File: rtl/dwq_retire.sv
module dwq_retire #(
  parameter int SLOTS = 8,
  parameter int PW    = 3,
  parameter int CNT_W = 4
) (
  input  logic             tick_i,
  input  logic [PW-1:0]    rd_ptr_i,
  input  logic [SLOTS-1:0] live_i,
  input  logic [SLOTS-1:0] done_i,
  input  logic [SLOTS-1:0] expire_i,
  output logic [SLOTS-1:0] rel_o,
  output logic [CNT_W-1:0] rel_n_o
);
  logic          chain;
  logic [PW-1:0] idx;

  // Free the run of written entries that starts at the oldest one.
  always_comb begin
    chain   = tick_i;
    rel_o   = '0;
    rel_n_o = '0;
    idx     = '0;
    for (int k = 0; k < SLOTS; k++) begin
      idx        = PW'((int'(rd_ptr_i) + k) % SLOTS);
      chain      = chain && live_i[idx] && (done_i[idx] || expire_i[idx]);
      rel_o[idx] = chain;
      if (chain) rel_n_o = rel_n_o + CNT_W'(1);
    end
  end
endmodule

// File: rtl/delayed_write_queue.sv
module delayed_write_queue
  import dwq_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int DLY_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    inval,
  input  logic                    sch_valid,
  output logic                    sch_ready,
  input  logic                    sch_fill,
  input  logic [REG_W-1:0]        sch_reg,
  input  logic [DATA_W-1:0]       sch_data,
  input  logic [DLY_W-1:0]        sch_delay,
  input  logic                    sch_wide,
  input  logic                    sch_bit_en,
  input  logic [BIT_W-1:0]        sch_bit,
  input  logic                    tick,
  output logic [SLOTS-1:0]        wr_en,
  output logic [SLOTS-1:0]        wr_fpr,
  output logic [SLOTS*REG_W-1:0]  wr_idx,
  output logic [SLOTS*DATA_W-1:0] wr_data,
  output logic [SLOTS*DATA_W-1:0] wr_mask,
  output logic                    ovf_err,
  output logic                    ptr_err
);
  localparam int PW    = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int CNT_W = $clog2(SLOTS + 1);
  localparam logic [DATA_W-1:0] LOW_SPAN = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CNT_W-1:0] occ;
  logic [SLOTS-1:0] live, done, expire, rel, load;
  logic [CNT_W-1:0] rel_n;
  wr_ent_t          slot_ent [SLOTS];
  wr_ent_t          ent_new;
  logic [DLY_W-1:0] delay_new;
  logic             accept;

  logic              lane_fpr  [SLOTS];
  logic [REG_W-1:0]  lane_idx  [SLOTS];
  logic [DATA_W-1:0] lane_mask [SLOTS];
  logic [DATA_W-1:0] lane_data [SLOTS];

  // Legacy fill overrides delay and width and forbids bit mode.
  always_comb begin
    ent_new.dst    = sch_reg;
    ent_new.val    = sch_data;
    ent_new.wide   = sch_fill | sch_wide;
    ent_new.bit_en = !sch_fill && sch_bit_en;
    ent_new.bitn   = sch_bit;
    delay_new      = sch_fill ? DLY_W'(LEGACY_DELAY) : sch_delay;
  end

  assign sch_ready = !live[wr_ptr];
  assign accept    = sch_valid && sch_ready && !inval;

  dwq_retire #(.SLOTS(SLOTS), .PW(PW), .CNT_W(CNT_W)) u_retire (
    .tick_i   (tick),
    .rd_ptr_i (rd_ptr),
    .live_i   (live),
    .done_i   (done),
    .expire_i (expire),
    .rel_o    (rel),
    .rel_n_o  (rel_n)
  );

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [DATA_W-1:0] span;
    logic [DATA_W-1:0] one_bit;

    assign load[g] = accept && (wr_ptr == PW'(g));

    dwq_slot #(.DLY_W(DLY_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (inval),
      .load_i    (load[g]),
      .ent_i     (ent_new),
      .delay_i   (delay_new),
      .tick_i    (tick),
      .release_i (rel[g]),
      .live_o    (live[g]),
      .done_o    (done[g]),
      .expire_o  (expire[g]),
      .ent_o     (slot_ent[g])
    );

    dwq_bank_map u_map (
      .flat_i (slot_ent[g].dst),
      .fpr_o  (lane_fpr[g]),
      .idx_o  (lane_idx[g])
    );

    assign span         = slot_ent[g].wide ? {DATA_W{1'b1}} : LOW_SPAN;
    assign one_bit      = DATA_W'(1) << slot_ent[g].bitn;
    assign lane_mask[g] = slot_ent[g].bit_en ? (span & one_bit) : span;
    assign lane_data[g] = slot_ent[g].bit_en ? ((|slot_ent[g].val) ? lane_mask[g] : '0)
                                             : (slot_ent[g].val & span);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      occ     <= '0;
      ovf_err <= 1'b0;
      ptr_err <= 1'b0;
      wr_en   <= '0;
      wr_fpr  <= '0;
      wr_idx  <= '0;
      wr_data <= '0;
      wr_mask <= '0;
    end else if (inval) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      occ     <= '0;
      ovf_err <= 1'b0;
      ptr_err <= 1'b0;
      wr_en   <= '0;
    end else begin
      if (accept) wr_ptr <= (wr_ptr == PW'(SLOTS - 1)) ? '0 : wr_ptr + PW'(1);
      rd_ptr  <= PW'((int'(rd_ptr) + int'(rel_n)) % SLOTS);
      occ     <= occ - rel_n + CNT_W'(accept);
      ovf_err <= sch_valid && !sch_ready;
      ptr_err <= tick && (rd_ptr != wr_ptr) && (occ == '0);
      for (int i = 0; i < SLOTS; i++) begin
        wr_en[i] <= expire[i];
        if (expire[i]) begin
          wr_fpr[i]                   <= lane_fpr[i];
          wr_idx[i*REG_W +: REG_W]    <= lane_idx[i];
          wr_data[i*DATA_W +: DATA_W] <= lane_data[i];
          wr_mask[i*DATA_W +: DATA_W] <= lane_mask[i];
        end
      end
    end
  end

  AST_OCC_MATCHES_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) == $countones(live)); // R7
  AST_NO_PTR_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> !((rd_ptr != wr_ptr) && (occ == '0))); // R9
  AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sch_valid && !sch_ready && !inval) |=> (ovf_err && $stable(wr_ptr))); // R6
  AST_INVAL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    inval |=> ((occ == '0) && (live == '0) && (wr_en == '0))); // R10
  AST_WRITE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_en) |-> $past(tick)); // R2
endmodule

// File: tb/delayed_write_queue_bench.sv
`timescale 1ns/1ps
module delayed_write_queue_bench;
  import dwq_pkg::*;
  localparam int SLOTS = 8;
  localparam int DLY_W = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, inval, sch_valid, sch_ready, sch_fill, sch_wide, sch_bit_en, tick;
  logic [REG_W-1:0]        sch_reg;
  logic [DATA_W-1:0]       sch_data;
  logic [DLY_W-1:0]        sch_delay;
  logic [BIT_W-1:0]        sch_bit;
  logic [SLOTS-1:0]        wr_en, wr_fpr;
  logic [SLOTS*REG_W-1:0]  wr_idx;
  logic [SLOTS*DATA_W-1:0] wr_data, wr_mask;
  logic                    ovf_err, ptr_err;

  delayed_write_queue #(.SLOTS(SLOTS), .DLY_W(DLY_W)) u_delayed_write_queue (
    .clk(clk), .rst_n(rst_n), .inval(inval), .sch_valid(sch_valid), .sch_ready(sch_ready),
    .sch_fill(sch_fill), .sch_reg(sch_reg), .sch_data(sch_data), .sch_delay(sch_delay),
    .sch_wide(sch_wide), .sch_bit_en(sch_bit_en), .sch_bit(sch_bit), .tick(tick),
    .wr_en(wr_en), .wr_fpr(wr_fpr), .wr_idx(wr_idx), .wr_data(wr_data), .wr_mask(wr_mask),
    .ovf_err(ovf_err), .ptr_err(ptr_err)
  );

  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;
  string tag = "R1";

  typedef struct {
    int          slot;
    int          cnt;
    bit          done;
    int          dst;
    logic [63:0] val;
    bit          wide;
    bit          ben;
    int          bitn;
  } ment_t;

  ment_t       q[$];
  int          wp = 0;
  bit          e_en  [SLOTS];
  bit          e_fpr [SLOTS];
  int          e_idx [SLOTS];
  logic [63:0] e_data[SLOTS];
  logic [63:0] e_mask[SLOTS];
  bit          e_ovf = 0;

  task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic compare();
    for (int i = 0; i < SLOTS; i++) begin
      chk(tag, $sformatf("wr_en[%0d]", i), 64'(wr_en[i]), 64'(e_en[i]));
      if (e_en[i] && wr_en[i]) begin
        chk(tag, $sformatf("wr_fpr[%0d]", i), 64'(wr_fpr[i]), 64'(e_fpr[i]));
        chk(tag, $sformatf("wr_idx[%0d]", i), 64'(wr_idx[i*REG_W +: REG_W]), 64'(e_idx[i]));
        chk(tag, $sformatf("wr_data[%0d]", i), wr_data[i*DATA_W +: DATA_W], e_data[i]);
        chk(tag, $sformatf("wr_mask[%0d]", i), wr_mask[i*DATA_W +: DATA_W], e_mask[i]);
      end
    end
    chk(tag, "sch_ready", 64'(sch_ready), 64'(q.size() < SLOTS));
    chk(tag, "ovf_err", 64'(ovf_err), 64'(e_ovf));
    chk("R9", "ptr_err", 64'(ptr_err), 64'd0);
  endtask

  task automatic deliver(ment_t e);
    logic [63:0] span, m;
    span = e.wide ? '1 : 64'h0000_0000_FFFF_FFFF;
    e_en[e.slot]  = 1;
    e_fpr[e.slot] = (e.dst >= 38) && (e.dst < 70);
    e_idx[e.slot] = e_fpr[e.slot] ? e.dst - 38 : e.dst;
    if (e.ben) begin
      m = (64'd1 << e.bitn) & span;
      e_mask[e.slot] = m;
      e_data[e.slot] = (e.val != 0) ? m : 64'd0;
    end else begin
      e_mask[e.slot] = span;
      e_data[e.slot] = e.val & span;
    end
  endtask

  task automatic model(bit v, bit fill, int dst, logic [63:0] val, int dly, bit wide,
                       bit ben, int bitn, bit tk, bit inv);
    bit    rdy;
    ment_t n;
    for (int i = 0; i < SLOTS; i++) e_en[i] = 0;
    e_ovf = 0;
    if (inv) begin
      q.delete();
      wp = 0;
      return;
    end
    rdy = q.size() < SLOTS;
    if (tk) begin
      for (int k = 0; k < q.size(); k++) begin
        if (!q[k].done) begin
          q[k].cnt--;
          if (q[k].cnt == 0) begin
            q[k].done = 1;
            deliver(q[k]);
          end
        end
      end
      while (q.size() > 0 && q[0].done) void'(q.pop_front());
    end
    if (v) begin
      if (rdy) begin
        n.slot = wp;
        n.cnt  = (fill ? 2 : dly) + 1;
        n.done = 0;
        n.dst  = dst;
        n.val  = val;
        n.wide = fill | wide;
        n.ben  = !fill && ben;
        n.bitn = bitn;
        q.push_back(n);
        wp = (wp + 1) % SLOTS;
      end else begin
        e_ovf = 1;
      end
    end
  endtask

  task automatic cyc(bit v, bit fill, int dst, logic [63:0] val, int dly, bit wide,
                     bit ben, int bitn, bit tk, bit inv);
    @(negedge clk);
    compare();
    sch_valid  = v;
    sch_fill   = fill;
    sch_reg    = REG_W'(dst);
    sch_data   = val;
    sch_delay  = DLY_W'(dly);
    sch_wide   = wide;
    sch_bit_en = ben;
    sch_bit    = BIT_W'(bitn);
    tick       = tk;
    inval      = inv;
    model(v, fill, dst, val, dly, wide, ben, bitn, tk, inv);
  endtask

  task automatic idle(int n, bit tk);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 64'd0, 0, 0, 0, 0, tk, 0);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    rst_n = 0; inval = 0; sch_valid = 0; sch_fill = 0; sch_reg = '0; sch_data = '0;
    sch_delay = '0; sch_wide = 0; sch_bit_en = 0; sch_bit = '0; tick = 0;
    for (int i = 0; i < SLOTS; i++) e_en[i] = 0;
    repeat (3) @(negedge clk);
    tag = "R1";
    compare();                               // R1: state while in reset
    rst_n = 1;
    idle(3, 1);

    tag = "R2";                              // delays 0, 1, 3, with gaps between ticks
    cyc(1, 0, 5, 64'h1122_3344_5566_7788, 0, 1, 0, 0, 0, 0);
    cyc(1, 0, 6, 64'h0BAD_F00D_0000_0001, 1, 1, 0, 0, 0, 0);
    cyc(1, 0, 7, 64'h8000_0000_0000_0000, 3, 1, 0, 0, 0, 0);
    for (int k = 0; k < 10; k++) cyc(0, 0, 0, 64'd0, 0, 0, 0, 0, (k % 2) == 0, 0);

    tag = "R3";                              // schedule on the same edge as a tick
    cyc(1, 0, 9, 64'h1234, 1, 1, 0, 0, 1, 0);
    idle(4, 1);

    tag = "R4";                              // 32-bit versus 64-bit full writes
    cyc(1, 0, 3, 64'hFFFF_0000_ABCD_1234, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 4, 64'hFFFF_0000_ABCD_1234, 0, 1, 0, 0, 1, 0);
    idle(4, 1);

    tag = "R5";                              // single-bit set and clear
    cyc(1, 0, 11, 64'd1, 0, 1, 1, 40, 0, 0);
    cyc(1, 0, 12, 64'd0, 0, 0, 1, 7, 0, 0);
    cyc(1, 0, 13, 64'd5, 0, 0, 1, 35, 0, 0);
    cyc(1, 0, 14, 64'h100, 0, 0, 1, 31, 0, 0);
    idle(4, 1);

    tag = "R8";                              // legacy fill and bank mapping
    cyc(1, 1, 10, 64'hAAAA_5555_AAAA_5555, 9, 0, 1, 3, 0, 0);
    cyc(1, 1, 38, 64'h0123_4567_89AB_CDEF, 0, 0, 0, 0, 0, 0);
    cyc(1, 1, 69, 64'hFEDC_BA98_7654_3210, 0, 0, 0, 0, 0, 0);
    cyc(1, 1, 70, 64'h0000_0000_0000_0F0F, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 37, 64'h77, 0, 1, 0, 0, 0, 0);
    idle(6, 1);

    tag = "R7";                              // long entry blocks freeing of short ones
    cyc(1, 0, 1, 64'h11, 9, 1, 0, 0, 0, 0);
    for (int k = 0; k < 7; k++) cyc(1, 0, 2 + k, 64'(k), 0, 1, 0, 0, 0, 0);
    cyc(1, 0, 20, 64'h99, 0, 1, 0, 0, 1, 0);
    cyc(1, 0, 20, 64'h99, 0, 1, 0, 0, 1, 0);
    idle(12, 1);

    tag = "R6";                              // fill the ring, then overflow
    for (int k = 0; k < SLOTS; k++) cyc(1, 0, 15 + k, 64'(k + 100), 3, 0, 0, 0, 0, 0);
    cyc(1, 0, 30, 64'hDEAD, 0, 1, 0, 0, 0, 0);
    cyc(1, 0, 31, 64'hBEEF, 0, 1, 0, 0, 1, 0);
    idle(3, 1);
    cyc(1, 0, 32, 64'hCAFE, 0, 1, 0, 0, 1, 0);
    idle(6, 1);

    tag = "R10";                             // discard pending work
    cyc(1, 0, 40, 64'h1, 2, 1, 0, 0, 0, 0);
    cyc(1, 0, 41, 64'h2, 2, 1, 0, 0, 1, 0);
    cyc(1, 0, 42, 64'h3, 0, 1, 0, 0, 1, 1);
    idle(6, 1);

    tag = "R11";                             // allocation from lane 0 and mixed traffic
    cyc(1, 0, 50, 64'h5, 0, 1, 0, 0, 0, 0);
    idle(3, 1);
    lf = 16'hACE1;
    for (int k = 0; k < 600; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc(lf[0], lf[9] & lf[10], int'(lf[15:9]), {lf, ~lf, lf ^ 16'h5A5A, 16'(k)},
          int'(lf[3:1]), lf[4], lf[5] & lf[6], int'(lf[14:9]),
          lf[7] | lf[8], (lf[15:10] == 6'd0));
    end
    idle(20, 1);
    @(negedge clk);
    compare();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule